// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches by running two direction predictors side by side and letting a third table decide which one to trust for each branch. The global predictor hashes a shift register of recent outcomes from every branch with the branch address. It uses the result to pick a 2-bit saturating counter. The local predictor first looks up the branch's own outcome history in a per-address history table. It then uses that history alone to pick a 2-bit counter from a pattern table.

A per-address table of 2-bit selector counters records which of the two predictors has been right more often for that branch. The lookup port forwards that predictor's answer.

The lookup port is purely combinational. A fetch stage presents a PC and receives the final direction together with both component directions. When the branch resolves, the pipeline presents the same PC, the real outcome and the two component directions that were returned at lookup. On that clock edge the block trains all three tables and the global history.

Top module: `hdp_tournament`

## Requirements
- R1: After reset every global and pattern counter holds 0, every local history and the global history hold 0, and every selector counter holds 1 (weakly local). Any lookup then returns not-taken on all three outputs.
- R2: The global direction comes from the global counter at index `lk_pc[5:2] XOR ghist`. It is taken when that counter is 2 or 3.
- R3: Every counter is a 2-bit saturating counter. An update with outcome taken raises it by one up to 3. An update with outcome not-taken lowers it by one down to 0.
- R4: Each valid update shifts the 4-bit global history left by one place and puts the new outcome (1 = taken) in bit 0. The global counter trained is the one at `up_pc[5:2] XOR ghist`, using the history held before that shift.
- R5: The local history entry is selected by `pc[5:2]`. Its 4-bit value indexes a 16-entry pattern table, and the local direction is taken when the selected counter is 2 or 3. An update trains the counter selected by the entry's current history, then shifts the outcome into bit 0 of that entry.
- R6: The selector counter at `lk_pc[5:2]` forwards the global direction when it holds 2 or 3, and the local direction when it holds 0 or 1. When both components agree, the final direction equals them.
- R7: A selector counter changes only on an update where `up_gpred` differs from `up_lpred`. It moves up by one (toward global) if `up_gpred` equals the outcome, and down by one otherwise, saturating at 0 and 3.
- R8: Lookup reflects the state present before the current clock edge. An update is seen by lookups from the following cycle onward, including a lookup of the same PC in the same cycle.
- R9: While `up_valid` is low, no table or history changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | Lookup branch address |
| lk_taken | output | 1 | Final predicted direction (1 = taken) |
| lk_gpred | output | 1 | Global component direction |
| lk_lpred | output | 1 | Local component direction |
| up_valid | input | 1 | Resolved branch present this cycle |
| up_pc | input | 32 | Resolved branch address |
| up_taken | input | 1 | Actual outcome (1 = taken) |
| up_gpred | input | 1 | Global direction returned at lookup |
| up_lpred | input | 1 | Local direction returned at lookup |

## Verification
The bench drives a loop-shaped branch with a repeating taken-taken-taken-not pattern. A design that trained the pattern counter after shifting the local history, instead of before, would never learn the exit iteration. It injects component predictions that disagree in both directions. A selector that also moved on agreement, or moved the wrong way, would then switch predictors on the wrong branches. Lookups and updates of the same PC in one cycle expose any write-through path that shows a new counter a cycle early. Long runs of one outcome catch counters that wrap instead of saturating, and idle cycles with garbage on the update inputs catch training that ignores `up_valid`.

// File: rtl/hdp_pkg.sv
package hdp_pkg;

   typedef logic [1:0] ctr2_t;

   localparam ctr2_t CTR_ZERO    = 2'd0;
   localparam ctr2_t CTR_WEAK_LO = 2'd1;

   // Upper half of the counter range means "taken" / "pick global".
   function automatic logic ctr_high(input ctr2_t c);
      return c[1];
   endfunction

   function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
      ctr2_t r;
      if (up) r = (c == 2'd3) ? c : c + 2'd1;
      else    r = (c == 2'd0) ? c : c - 2'd1;
      return r;
   endfunction

endpackage

// File: rtl/hdp_ctr_table.sv
module hdp_ctr_table
   import hdp_pkg::*;
#(
   parameter int    IDX_W = 4,
   parameter ctr2_t INIT  = CTR_ZERO
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_high,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up
);

   localparam int DEPTH = 1 << IDX_W;

   ctr2_t ent [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent[e] <= INIT;
         else if (wr_en && (wr_idx == IDX_W'(e)))
            ent[e] <= ctr_step(ent[e], wr_up);
      end
   end

   assign rd_high = ctr_high(ent[rd_idx]);

endmodule

// File: rtl/hdp_hist_table.sv
module hdp_hist_table #(
   parameter int IDX_W  = 4,
   parameter int HIST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx_a,
   output logic [HIST_W-1:0] rd_hist_a,
   input  logic [IDX_W-1:0]  rd_idx_b,
   output logic [HIST_W-1:0] rd_hist_b,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_bit
);

   localparam int DEPTH = 1 << IDX_W;

   if (HIST_W < 2) begin : g_bad_hist
      $error("hdp_hist_table: HIST_W must be at least 2");
   end

   logic [HIST_W-1:0] hist [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hist[e] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(e)))
            hist[e] <= {hist[e][HIST_W-2:0], wr_bit};
      end
   end

   assign rd_hist_a = hist[rd_idx_a];
   assign rd_hist_b = hist[rd_idx_b];

endmodule

// File: rtl/hdp_tournament.sv
module hdp_tournament
   import hdp_pkg::*;
#(
   parameter int PC_W     = 32,
   parameter int PC_LSB   = 2,
   parameter int GHIST_W  = 4,
   parameter int LIDX_W   = 4,
   parameter int LHIST_W  = 4,
   parameter int CIDX_W   = 4,
   parameter bit XOR_HASH = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_taken,
   output logic            lk_gpred,
   output logic            lk_lpred,
   input  logic            up_valid,
   input  logic [PC_W-1:0] up_pc,
   input  logic            up_taken,
   input  logic            up_gpred,
   input  logic            up_lpred
);

   localparam int MAX_IDX_W = (GHIST_W > LIDX_W) ?
                              ((GHIST_W > CIDX_W) ? GHIST_W : CIDX_W) :
                              ((LIDX_W  > CIDX_W) ? LIDX_W  : CIDX_W);

   if (PC_LSB + MAX_IDX_W > PC_W) begin : g_bad_pc
      $error("hdp_tournament: index bits exceed PC width");
   end
   if (GHIST_W < 2) begin : g_bad_ghist
      $error("hdp_tournament: GHIST_W must be at least 2");
   end

   // ---------------- global history ----------------
   logic [GHIST_W-1:0] ghr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ghr_q <= '0;
      else if (up_valid) ghr_q <= {ghr_q[GHIST_W-2:0], up_taken};
   end

   // ---------------- index formation ----------------
   logic [GHIST_W-1:0] lk_gidx, up_gidx;
   logic [LIDX_W-1:0]  lk_lidx, up_lidx;
   logic [CIDX_W-1:0]  lk_cidx, up_cidx;

   if (XOR_HASH) begin : g_hash_xor
      assign lk_gidx = lk_pc[PC_LSB +: GHIST_W] ^ ghr_q;
      assign up_gidx = up_pc[PC_LSB +: GHIST_W] ^ ghr_q;
   end else begin : g_hash_hist
      assign lk_gidx = ghr_q;
      assign up_gidx = ghr_q;
   end

   assign lk_lidx = lk_pc[PC_LSB +: LIDX_W];
   assign up_lidx = up_pc[PC_LSB +: LIDX_W];
   assign lk_cidx = lk_pc[PC_LSB +: CIDX_W];
   assign up_cidx = up_pc[PC_LSB +: CIDX_W];

   // ---------------- global component ----------------
   hdp_ctr_table #(.IDX_W(GHIST_W), .INIT(CTR_ZERO)) u_gtab (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (lk_gidx),
      .rd_high (lk_gpred),
      .wr_en   (up_valid),
      .wr_idx  (up_gidx),
      .wr_up   (up_taken)
   );

   // ---------------- local component ----------------
   logic [LHIST_W-1:0] lk_lhist, up_lhist;

   hdp_hist_table #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lhist (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx_a  (lk_lidx),
      .rd_hist_a (lk_lhist),
      .rd_idx_b  (up_lidx),
      .rd_hist_b (up_lhist),
      .wr_en     (up_valid),
      .wr_idx    (up_lidx),
      .wr_bit    (up_taken)
   );

   hdp_ctr_table #(.IDX_W(LHIST_W), .INIT(CTR_ZERO)) u_ptab (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (lk_lhist),
      .rd_high (lk_lpred),
      .wr_en   (up_valid),
      .wr_idx  (up_lhist),
      .wr_up   (up_taken)
   );

   // ---------------- selector ----------------
   logic lk_pick_g;
   logic sel_wr, sel_up;

   assign sel_wr = up_valid && (up_gpred != up_lpred);
   assign sel_up = (up_gpred == up_taken);

   hdp_ctr_table #(.IDX_W(CIDX_W), .INIT(CTR_WEAK_LO)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (lk_cidx),
      .rd_high (lk_pick_g),
      .wr_en   (sel_wr),
      .wr_idx  (up_cidx),
      .wr_up   (sel_up)
   );

   assign lk_taken = lk_pick_g ? lk_gpred : lk_lpred;

endmodule

// File: rtl/hdp_tournament_chk.sv
module hdp_tournament_chk #(
   parameter int PC_W    = 32,
   parameter int GHIST_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [PC_W-1:0]    lk_pc,
   input logic               lk_taken,
   input logic               lk_gpred,
   input logic               lk_lpred,
   input logic               up_valid,
   input logic               up_taken,
   input logic [GHIST_W-1:0] ghr
);

   // R6: agreeing components leave the selector nothing to decide
   assert_agree_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_gpred == lk_lpred) |-> (lk_taken == lk_gpred));

   // R9: global history frozen without a valid update
   assert_ghist_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !up_valid |=> $stable(ghr));

   // R4: newest outcome lands in bit 0
   assert_ghist_newest_R4: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |=> (ghr[0] == $past(up_taken)));

   // R8: with no training edge, a held PC keeps its answer
   assert_lookup_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !up_valid |=> (!$stable(lk_pc) || $stable({lk_taken, lk_gpred, lk_lpred})));

endmodule

bind hdp_tournament hdp_tournament_chk #(.PC_W(PC_W), .GHIST_W(GHIST_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lk_pc    (lk_pc),
   .lk_taken (lk_taken),
   .lk_gpred (lk_gpred),
   .lk_lpred (lk_lpred),
   .up_valid (up_valid),
   .up_taken (up_taken),
   .ghr      (ghr_q)
);

// File: tb/hdp_tournament_tb_top.sv
module hdp_tournament_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_taken, lk_gpred, lk_lpred;
   logic        up_valid = 1'b0;
   logic [31:0] up_pc = '0;
   logic        up_taken = 1'b0, up_gpred = 1'b0, up_lpred = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   hdp_tournament dut_i (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
      .lk_taken(lk_taken), .lk_gpred(lk_gpred), .lk_lpred(lk_lpred),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
      .up_gpred(up_gpred), .up_lpred(up_lpred)
   );

   // ---------------- behavioural reference ----------------
   int gm[16];
   int pm[16];
   int cm[16];
   int lh[16];
   int gh;

   int    n_cmp = 0;
   int    n_bad = 0;
   string phase = "R1";
   bit    done = 1'b0;

   function automatic int sat(input int v, input bit up);
      if (up) return (v < 3) ? v + 1 : 3;
      return (v > 0) ? v - 1 : 0;
   endfunction

   function automatic int pidx(input logic [31:0] pc);
      return int'(pc[5:2]);
   endfunction

   function automatic bit m_g(input logic [31:0] pc);
      return gm[pidx(pc) ^ gh] >= 2;
   endfunction

   function automatic bit m_l(input logic [31:0] pc);
      return pm[lh[pidx(pc)]] >= 2;
   endfunction

   function automatic bit m_t(input logic [31:0] pc);
      return (cm[pidx(pc)] >= 2) ? m_g(pc) : m_l(pc);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) begin
            gm[i] = 0; pm[i] = 0; cm[i] = 1; lh[i] = 0;
         end
         gh = 0;
      end else if (up_valid) begin
         int gi, li, hv;
         gi = pidx(up_pc) ^ gh;
         li = pidx(up_pc);
         hv = lh[li];
         gm[gi] = sat(gm[gi], up_taken);
         pm[hv] = sat(pm[hv], up_taken);
         if (up_gpred != up_lpred)
            cm[li] = sat(cm[li], up_gpred == up_taken);
         lh[li] = ((hv << 1) | int'(up_taken)) & 15;
         gh = ((gh << 1) | int'(up_taken)) & 15;
      end
   end

   // ---------------- comparison, away from the active edge ----------------
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit eg, el, et;
         eg = m_g(lk_pc); el = m_l(lk_pc); et = m_t(lk_pc);
         n_cmp++;
         if (lk_gpred !== eg || lk_lpred !== el || lk_taken !== et) begin
            n_bad++;
            $display("FAIL %s pc=%h: got t/g/l=%b%b%b expected %b%b%b",
                     phase, lk_pc, lk_taken, lk_gpred, lk_lpred, et, eg, el);
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic drive(input logic [31:0] lpc, input bit uv,
                        input logic [31:0] upc, input bit ut,
                        input bit ug, input bit ul);
      @(posedge clk);
      #2;
      lk_pc = lpc; up_valid = uv; up_pc = upc;
      up_taken = ut; up_gpred = ug; up_lpred = ul;
   endtask

   // realistic training: component directions as the model predicts now
   task automatic train(input logic [31:0] pc, input bit t);
      drive(pc, 1'b1, pc, t, m_g(pc), m_l(pc));
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1: fresh state, all lookups not-taken
      phase = "R1";
      for (int i = 0; i < 20; i++) drive(32'h1000 + 32'(i * 4), 1'b0, '0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      n_cmp++;
      if ({lk_taken, lk_gpred, lk_lpred} !== 3'b000) begin
         n_bad++;
         $display("FAIL R1: got %b%b%b expected 000", lk_taken, lk_gpred, lk_lpred);
      end

      // R3: long runs of one outcome must saturate, not wrap
      phase = "R3";
      for (int i = 0; i < 12; i++) train(32'h40, 1'b1);
      for (int i = 0; i < 12; i++) train(32'h40, 1'b0);

      // R4: alternating outcomes across pcs exercise the history shift
      phase = "R4";
      for (int i = 0; i < 32; i++) train(32'h200 + 32'((i % 3) * 4), 1'(i % 2));

      // R5: loop branch TTTN, learned by the local side
      phase = "R5";
      for (int i = 0; i < 40; i++) train(32'h100, (i % 4) != 3);

      // R7: forced disagreement in both directions, plus agreement
      phase = "R7";
      for (int i = 0; i < 6; i++) drive(32'h80, 1'b1, 32'h80, 1'b1, 1'b1, 1'b0);
      for (int i = 0; i < 6; i++) drive(32'h80, 1'b1, 32'h80, 1'b1, 1'b0, 1'b1);
      for (int i = 0; i < 6; i++) drive(32'h84, 1'b1, 32'h84, 1'b0, 1'b1, 1'b1);
      for (int i = 0; i < 3; i++) drive(32'h84, 1'b1, 32'h84, 1'b0, 1'b1, 1'b0);

      // R6: selector now set for some pcs; mixed pcs read both sides
      phase = "R6";
      for (int i = 0; i < 40; i++) train(32'h80 + 32'((i % 4) * 4), (i % 5) < 3);

      // R8: lookup and update on the same pc in the same cycle
      phase = "R8";
      for (int i = 0; i < 20; i++) train(32'h3c, 1'(i % 3 == 0));

      // R9: update inputs full of junk while not valid
      phase = "R9";
      for (int i = 0; i < 30; i++)
         drive(32'h100 + 32'(i * 4), 1'b0, 32'(i * 52), 1'(i % 2), 1'(i % 3 == 0), 1'(i % 5 == 0));

      // R2: pseudo-random branch stream across all table rows
      phase = "R2";
      lfsr = 16'hace1;
      for (int i = 0; i < 400; i++) begin
         logic [31:0] pc;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         pc = {24'h0, 2'b00, lfsr[3:0], 2'b00};
         if (lfsr[7]) train(pc, lfsr[9] | lfsr[4]);
         else drive(pc, 1'b0, 32'hdead_beef, lfsr[5], lfsr[6], lfsr[8]);
      end

      drive(32'h0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      #1;
      finish_run();
   end

endmodule